// File: doc/BRIEF.md
# Serial Channel Register Bank

This block is the software-facing half of one serial I/O channel. A processor reaches it through a byte-wide bus with a byte address inside a 256-byte window, and sees six control and status words plus two data ports. Behind the data ports sit two small byte FIFOs. The transmit FIFO drains towards the line logic over a valid/ready byte stream. The receive FIFO is filled by the line logic over a second valid/ready byte stream.

Two sticky status flags report FIFO conditions. One flag says that received data is waiting, and the other says that the transmit queue has run dry. A control word selects which status bits drive the single level-sensitive interrupt line. A FIFO control word can empty either queue, but only when its guard bit is written in the same word. Bit-level framing, baud timing, flow control and DMA belong to other blocks. The baud, line and DMA-enable fields are only stored here.

Top module: `sio_regbank`

## Requirements
- R1: After reset, both FIFOs are empty, the line control word reads 0x40000000, the baud word reads 0x03FF0000, and every other register reads zero. The transmit flag then sets on the first clock because the transmit FIFO is empty.
- R2: Words are big-endian across byte lanes. Address offset 0 is bits 31:24, offset 1 is bits 23:16, offset 2 is bits 15:8 and offset 3 is bits 7:0. A byte write replaces only its own lane. Read data appears on bus_rdata one clock after the read request.
- R3: The word offsets are 0x00 line control, 0x04 line status, 0x08 interrupt control, 0x0C interrupt status, 0x10 FIFO control, 0x14 baud, 0x20 transmit data and 0x30 receive data. Each register keeps only its writable bits: line control 0xE17F0000, interrupt control 0x000F0000, interrupt status 0x00070000, FIFO control 0x001F0000 and baud 0xFF0000 with 0x03000000 (0x03FF0000 in total).
- R4: The line status word reads zero and ignores writes. A write to the receive data port has no effect. A read of the transmit data port returns zero.
- R5: Interrupt status bit 16 (receive flag) sets in any cycle in which the receive FIFO holds data. Bit 17 (transmit flag) sets in any cycle in which the transmit FIFO is empty. Both flags stay set until software writes them to 0, and a flag whose condition still holds sets again on the same edge.
- R6: irq is high exactly while interrupt status AND interrupt control is non-zero. In the control word, bit 16 enables receive, bit 17 enables transmit and bit 18 enables error. The error status bit 18 is set only by software.
- R7: FIFO control bit 16 is the flush guard, bit 17 flushes the receive FIFO and bit 18 flushes the transmit FIFO. A flush happens when a write leaves the guard set together with that flush bit. Without the guard, nothing is flushed.
- R8: A byte write to the transmit data port at offset 0 pushes that byte, and writes to offsets 1 to 3 push nothing. Bytes leave on tx_data in push order, one per clock in which tx_valid and tx_ready are both high.
- R9: A read of the receive data port at offset 0 pops the oldest byte and returns it. A read at offsets 1 to 3 returns zero and pops nothing. A read of an empty FIFO returns zero.
- R10: Each FIFO holds 16 bytes. rx_ready is low while the receive FIFO is full. A transmit push into a full FIFO is dropped.
- R11: Interrupt control bit 19 (DMA enable) is stored and read back, and changes neither the FIFOs nor irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Bus access strobe, one access per clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the window |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the clock after the read |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit FIFO has a byte |
| tx_data | output | 8 | Head of transmit FIFO |
| tx_ready | input | 1 | Line side takes the head byte |
| rx_valid | input | 1 | Line side offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive FIFO has room |

## Verification
The bench goes after lane placement and masking. A design with reversed lanes or a late mask would return the written byte where it should return zero, or would corrupt neighbouring bytes. It clears the sticky flags while their causes are still present and while they are absent. A design that lets the clear win, or that makes the flags follow the FIFO level, would show the wrong irq. It tries flushes without the guard bit and data-port accesses on the wrong lanes, where a careless decode would lose or duplicate bytes. It also overfills both FIFOs, where a wrapping count would drop the wrong byte or reorder the stream.

// File: rtl/sio_regbank.sv
module sio_regbank #(
  parameter int DEPTH = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int XW = AW - 2;
  localparam logic [31:0] LCR_MASK = 32'hE17F0000;
  localparam logic [31:0] ICR_MASK = 32'h000F0000;
  localparam logic [31:0] ISR_MASK = 32'h00070000;
  localparam logic [31:0] FCR_MASK = 32'h001F0000;
  localparam logic [31:0] BGR_MASK = 32'h03FF0000;

  logic [XW-1:0] widx;
  logic [4:0]    sh;
  logic          wr, rd, lane0;
  assign widx  = bus_addr[AW-1:2];
  assign sh    = {~bus_addr[1:0], 3'b000};
  assign wr    = bus_cs & bus_we;
  assign rd    = bus_cs & ~bus_we;
  assign lane0 = bus_addr[1:0] == 2'd0;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] m,
                                        input logic [7:0] b, input logic [4:0] s);
    return ((old & ~(32'hFF << s)) | ({24'b0, b} << s)) & m;
  endfunction

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [31:0] lcr_q, icr_q, isr_q, fcr_q, bgr_q, isr_d, fcr_d;
  logic [7:0]  tx_mem [DEPTH];
  logic [7:0]  rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_push, tx_pop, rx_push, rx_pop, flush_tx, flush_rx, wr_fcr;

  assign wr_fcr   = wr && widx == XW'(4);
  assign fcr_d    = wr_fcr ? merge(fcr_q, FCR_MASK, bus_wdata, sh) : fcr_q;
  assign flush_rx = wr_fcr & fcr_d[16] & fcr_d[17];
  assign flush_tx = wr_fcr & fcr_d[16] & fcr_d[18];

  assign tx_valid = tx_cnt != '0;
  assign tx_data  = tx_mem[tx_rp];
  assign rx_ready = rx_cnt != CW'(DEPTH);
  assign tx_push  = wr && widx == XW'(8) && lane0 && tx_cnt != CW'(DEPTH);
  assign tx_pop   = tx_valid & tx_ready;
  assign rx_push  = rx_valid & rx_ready;
  assign rx_pop   = rd && widx == XW'(12) && lane0 && rx_cnt != '0;

  always_comb begin
    isr_d = isr_q;
    if (wr && widx == XW'(3)) isr_d = merge(isr_q, ISR_MASK, bus_wdata, sh);
    if (rx_cnt != '0) isr_d[16] = 1'b1;
    if (tx_cnt == '0) isr_d[17] = 1'b1;
  end

  assign irq = |(isr_q & icr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q <= 32'h40000000;
      bgr_q <= 32'h03FF0000;
      icr_q <= '0;
      isr_q <= '0;
      fcr_q <= '0;
    end else begin
      isr_q <= isr_d;
      fcr_q <= fcr_d;
      if (wr && widx == XW'(0)) lcr_q <= merge(lcr_q, LCR_MASK, bus_wdata, sh);
      if (wr && widx == XW'(2)) icr_q <= merge(icr_q, ICR_MASK, bus_wdata, sh);
      if (wr && widx == XW'(5)) bgr_q <= merge(bgr_q, BGR_MASK, bus_wdata, sh);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  logic [31:0] rd_word;
  always_comb begin
    case (widx)
      XW'(0):  rd_word = lcr_q;
      XW'(2):  rd_word = icr_q;
      XW'(3):  rd_word = isr_q;
      XW'(4):  rd_word = fcr_q;
      XW'(5):  rd_word = bgr_q;
      XW'(12): rd_word = rx_pop ? {rx_mem[rx_rp], 24'b0} : '0;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd) bus_rdata <= 8'(rd_word >> sh);
  end

  p_rx_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt != '0) |=> isr_q[16]);
  p_tx_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0) |=> isr_q[17]);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));
  p_rx_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && widx == XW'(12) && !lane0 && !rx_push) |=> rx_cnt == $past(rx_cnt));
  p_ls_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && widx == XW'(1)) |=> bus_rdata == 8'h00);
  p_full_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CW'(DEPTH)) |-> !rx_ready);
endmodule

// File: tb/sio_regbank_tb.sv
module sio_regbank_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cs = 0, bus_we = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic irq, tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic [7:0] tx_data, rx_data = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sio_regbank u_dut (.clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_cs = 0; d = bus_rdata;
  endtask

  task automatic push_rx(logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(8'h00, v); chk("R1 lc0", v, 8'h40);
    rd(8'h01, v); chk("R1 lc1", v, 8'h00);
    rd(8'h14, v); chk("R1 bg0", v, 8'h03);
    rd(8'h15, v); chk("R1 bg1", v, 8'hFF);
    rd(8'h09, v); chk("R1 ic1", v, 8'h00);
    rd(8'h0D, v); chk("R1 is1", v, 8'h02);
    chk("R1 irq", irq, 0); chk("R1 txv", tx_valid, 0); chk("R1 rxr", rx_ready, 1);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    for (int i = 0; i < 4; i++) wr(8'(i), 8'hFF);
    for (int i = 0; i < 4; i++) wr(8'(8'h14 + i), 8'hFF);
    rd(8'h00, v); chk("R3 lc0", v, 8'hE1);
    rd(8'h01, v); chk("R3 lc1", v, 8'h7F);
    rd(8'h03, v); chk("R3 lc3", v, 8'h00);
    rd(8'h14, v); chk("R3 bg0", v, 8'h03);
    rd(8'h17, v); chk("R3 bg3", v, 8'h00);
    wr(8'h11, 8'hFF); rd(8'h11, v); chk("R3 fc1", v, 8'h1F);
    wr(8'h11, 8'h00);
  endtask

  task automatic t_lanes();
    logic [7:0] v;
    wr(8'h01, 8'h92);
    rd(8'h01, v); chk("R2 lane1", v, 8'h12);
    rd(8'h00, v); chk("R2 lane0 kept", v, 8'hE1);
    wr(8'h00, 8'h40);
    rd(8'h00, v); chk("R2 lane0", v, 8'h40);
    rd(8'h01, v); chk("R2 lane1 kept", v, 8'h12);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    for (int i = 4; i < 8; i++) wr(8'(i), 8'hFF);
    for (int i = 4; i < 8; i++) begin rd(8'(i), v); chk("R4 ls", v, 8'h00); end
    wr(8'h30, 8'h77);
    rd(8'h30, v); chk("R4 rx write", v, 8'h00);
    rd(8'h20, v); chk("R4 tx read", v, 8'h00);
    chk("R4 txv", tx_valid, 0);
  endtask

  task automatic t_dma();
    logic [7:0] v;
    wr(8'h09, 8'hFF); rd(8'h09, v); chk("R3 ic mask", v, 8'h0F);
    wr(8'h09, 8'h08); rd(8'h09, v); chk("R11 dma stored", v, 8'h08);
    chk("R11 irq", irq, 0); chk("R11 txv", tx_valid, 0);
    wr(8'h09, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(8'h0D, 8'h00); rd(8'h0D, v); chk("R5 tx flag resets", v, 8'h02);
    wr(8'h20, 8'hAB); @(negedge clk);
    wr(8'h0D, 8'h00); rd(8'h0D, v); chk("R5 cleared", v, 8'h00);
    wr(8'h09, 8'h02); chk("R6 no irq", irq, 0);
    tx_ready = 1; @(negedge clk); tx_ready = 0; @(negedge clk);
    chk("R6 tx irq", irq, 1);
    wr(8'h0D, 8'h00); chk("R5 sticky refill", irq, 1);
    wr(8'h09, 8'h00); chk("R6 disabled", irq, 0);
    push_rx(8'h3C); @(negedge clk);
    wr(8'h09, 8'h01); chk("R6 rx irq", irq, 1);
    rd(8'h30, v); chk("R9 pop", v, 8'h3C);
    @(negedge clk); chk("R5 rx sticky", irq, 1);
    wr(8'h0D, 8'h00); chk("R5 rx clear", irq, 0);
    wr(8'h09, 8'h04); wr(8'h0D, 8'h04); chk("R6 err irq", irq, 1);
    wr(8'h0D, 8'h00); wr(8'h09, 8'h00); chk("R6 off", irq, 0);
  endtask

  task automatic drain(string req, logic [7:0] base, int exp_n);
    int n = 0;
    tx_ready = 1;
    while (tx_valid && n < 20) begin
      chk(req, tx_data, 8'(base + n)); n++; @(negedge clk);
    end
    tx_ready = 0;
    chk(req, 8'(n), 8'(exp_n));
  endtask

  task automatic t_order();
    wr(8'h21, 8'h11); wr(8'h22, 8'h22); wr(8'h23, 8'h33);
    chk("R8 other lanes", tx_valid, 0);
    for (int i = 0; i < 3; i++) wr(8'h20, 8'(8'hA1 + i));
    drain("R8 order", 8'hA1, 3);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    push_rx(8'h5A); push_rx(8'hC3);
    rd(8'h31, v); chk("R9 lane1", v, 8'h00);
    rd(8'h30, v); chk("R9 first", v, 8'h5A);
    rd(8'h30, v); chk("R9 second", v, 8'hC3);
    rd(8'h30, v); chk("R9 empty", v, 8'h00);
  endtask

  task automatic t_full();
    logic [7:0] v;
    for (int i = 0; i < 17; i++) push_rx(8'(8'h10 + i));
    chk("R10 rx_ready", rx_ready, 0);
    for (int i = 0; i < 16; i++) begin rd(8'h30, v); chk("R10 rx data", v, 8'(8'h10 + i)); end
    rd(8'h30, v); chk("R10 dropped", v, 8'h00);
    chk("R10 rx_ready back", rx_ready, 1);
    for (int i = 0; i < 17; i++) wr(8'h20, 8'(8'h80 + i));
    drain("R10 tx", 8'h80, 16);
  endtask

  task automatic t_flush();
    logic [7:0] v;
    push_rx(8'h61); push_rx(8'h62); push_rx(8'h63);
    wr(8'h20, 8'h71); wr(8'h20, 8'h72);
    wr(8'h11, 8'h06);
    rd(8'h30, v); chk("R7 no guard rx", v, 8'h61);
    chk("R7 no guard tx", tx_valid, 1);
    wr(8'h11, 8'h03);
    rd(8'h30, v); chk("R7 rx flushed", v, 8'h00);
    chk("R7 tx kept", tx_valid, 1);
    wr(8'h11, 8'h05);
    chk("R7 tx flushed", tx_valid, 0);
    wr(8'h11, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_masks(); t_lanes(); t_ignored(); t_dma();
    t_irq(); t_order(); t_rx(); t_full(); t_flush();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule